// File: doc/BRIEF.md
# Blocking One-Word Message Channel

This block carries one data word at a time from a sending processor (or task) to a receiving one, with both sides synchronised by a two-flag handshake. The sender loads a word into the channel register. It then sees its ready flag drop and stays blocked until the receiver has taken the word. The receiver sees a word-waiting flag rise and takes the word with a read strobe. Taking the word acknowledges it back to the sender, which frees the sender's side again.

Either side may open a transaction. If the receiver asks for a word before one has been sent, its request is held and the receiver is shown as blocked. The request then completes by itself once the sender supplies a word. The flags exist so that a scheduler can park whichever side is waiting and run other work until the exchange closes. A small controller sits on each side: the sender-side one owns the data register and the pending-word flag, and the receiver-side one owns the pending request and the delivered-word register. They talk only through the pending-word flag and a one-cycle acknowledge.

Top module: `msg_channel`

## Requirements
- R1: After reset, tx_ready_o is 1, rx_ready_o is 0, rx_wait_o is 0, rx_valid_o is 0 and rx_data_o is all zeros.
- R2: A load (tx_load_i = 1) in a cycle with tx_ready_o = 1 captures tx_data_i. From the next cycle, tx_ready_o is 0 and rx_ready_o is 1.
- R3: A load in a cycle with tx_ready_o = 0 is ignored. The word already held is the one delivered next, and the ready flags do not change.
- R4: A read (rx_read_i = 1) in a cycle with rx_ready_o = 1 takes the word. In the next cycle, rx_valid_o is 1 and rx_data_o is that word. In that same next cycle, rx_ready_o is 0 and tx_ready_o is back to 1.
- R5: rx_valid_o is high for exactly one cycle per delivered word. rx_data_o keeps the last delivered word until the next delivery.
- R6: A read in a cycle with rx_ready_o = 0 and rx_wait_o = 0 sets rx_wait_o in the next cycle. rx_wait_o stays 1, and rx_ready_o stays 0, for as long as no word is loaded.
- R7: While rx_wait_o = 1, the first cycle with rx_ready_o = 1 completes the held request without a new read strobe. In the next cycle, rx_valid_o is 1 with that word, and rx_wait_o and rx_ready_o are 0.
- R8: When a read takes a word in the same cycle as a load, the read delivers the old word and the load is ignored. If tx_load_i is held, the new word is accepted in the following cycle, when tx_ready_o has returned to 1.
- R9: A read strobe while rx_wait_o = 1 has no further effect. Each accepted load yields exactly one delivery, in load order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_load_i | input | 1 | Sender load strobe |
| tx_data_i | input | DATA_W | Word to send |
| tx_ready_o | output | 1 | Sender may load (0: sender blocked on an open transaction) |
| rx_read_i | input | 1 | Receiver read request strobe |
| rx_ready_o | output | 1 | A loaded word is waiting for the receiver |
| rx_wait_o | output | 1 | Receiver has a request outstanding and is blocked |
| rx_valid_o | output | 1 | One-cycle pulse: a word was delivered |
| rx_data_o | output | DATA_W | Last delivered word |

## Verification
The assertions check on every cycle the following rules:
- An accepted load blocks the sender, and the held word does not move while the sender is blocked.
- An acknowledge arrives only while a word is pending.
- Every take yields exactly one single-cycle delivery pulse, which coincides with the sender being free.
- A blocked receiver stays blocked until a word appears, and is released by that word's delivery.

Only the scenarios can show the following:
- A load that is ignored while the sender is blocked really leaves the delivered value unchanged.
- A read in the same cycle as a load delivers the old word before the new one.
- A stray read while the receiver is blocked produces no second delivery.
- Across long mixed sequences, words arrive in order with none lost or duplicated.

// File: rtl/msg_channel_pkg.sv
package msg_channel_pkg;

  typedef enum logic {
    TX_FREE = 1'b0,
    TX_HELD = 1'b1
  } tx_state_e;

  typedef enum logic {
    RX_IDLE    = 1'b0,
    RX_BLOCKED = 1'b1
  } rx_state_e;

endpackage

// File: rtl/msg_channel_tx.sv
module msg_channel_tx
  import msg_channel_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              ack_i,
  output logic              ready_o,
  output logic              new_o,
  output logic [DATA_W-1:0] data_o
);

  tx_state_e         state_q, state_d;
  logic [DATA_W-1:0] word_q;
  logic              accept;

  assign accept = load_i && (state_q == TX_FREE);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      TX_FREE: if (accept) state_d = TX_HELD;
      TX_HELD: if (ack_i)  state_d = TX_FREE;
      default: state_d = TX_FREE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= TX_FREE;
      word_q  <= '0;
    end else begin
      state_q <= state_d;
      if (accept) word_q <= data_i;
    end
  end

  assign ready_o = (state_q == TX_FREE);
  assign new_o   = (state_q == TX_HELD);
  assign data_o  = word_q;

  // R2: accepted load blocks the sender
  p_load_blocks_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && ready_o) |=> (!ready_o && new_o));

  // R3: held word never moves while the sender is blocked
  p_word_stable_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ready_o) |=> $stable(data_o));

  // R4: acknowledge only closes an open transaction
  p_ack_when_held_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i |-> new_o);

endmodule

// File: rtl/msg_channel_rx.sv
module msg_channel_rx
  import msg_channel_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              read_i,
  input  logic              avail_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              ack_o,
  output logic              wait_o,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o
);

  rx_state_e         state_q, state_d;
  logic              take;
  logic              valid_q;
  logic [DATA_W-1:0] out_q;

  // a held request completes as soon as a word shows up
  assign take = avail_i && (read_i || (state_q == RX_BLOCKED));

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      RX_IDLE:    if (read_i && !avail_i) state_d = RX_BLOCKED;
      RX_BLOCKED: if (avail_i)            state_d = RX_IDLE;
      default:    state_d = RX_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= RX_IDLE;
      valid_q <= 1'b0;
      out_q   <= '0;
    end else begin
      state_q <= state_d;
      valid_q <= take;
      if (take) out_q <= data_i;
    end
  end

  assign ack_o   = take;
  assign wait_o  = (state_q == RX_BLOCKED);
  assign valid_o = valid_q;
  assign data_o  = out_q;

  // R4: every take is delivered in the next cycle
  p_take_delivers_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |=> valid_o);

  // R5: delivery is a single-cycle pulse
  p_valid_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  // R6: an early read blocks the receiver
  p_early_read_blocks_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (read_i && !avail_i && !wait_o) |=> wait_o);

  // R6: blocked until a word appears
  p_stay_blocked_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wait_o && !avail_i) |=> wait_o);

  // R7: a waiting request is released by the word
  p_release_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wait_o && avail_i) |=> (valid_o && !wait_o));

endmodule

// File: rtl/msg_channel.sv
module msg_channel
  import msg_channel_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tx_load_i,
  input  logic [DATA_W-1:0] tx_data_i,
  output logic              tx_ready_o,
  input  logic              rx_read_i,
  output logic              rx_ready_o,
  output logic              rx_wait_o,
  output logic              rx_valid_o,
  output logic [DATA_W-1:0] rx_data_o
);

  logic              word_new;
  logic              word_ack;
  logic [DATA_W-1:0] word_held;

  msg_channel_tx #(.DATA_W(DATA_W)) u_tx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (tx_load_i),
    .data_i  (tx_data_i),
    .ack_i   (word_ack),
    .ready_o (tx_ready_o),
    .new_o   (word_new),
    .data_o  (word_held)
  );

  msg_channel_rx #(.DATA_W(DATA_W)) u_rx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .read_i  (rx_read_i),
    .avail_i (word_new),
    .data_i  (word_held),
    .ack_o   (word_ack),
    .wait_o  (rx_wait_o),
    .valid_o (rx_valid_o),
    .data_o  (rx_data_o)
  );

  assign rx_ready_o = word_new;

  // R4: a delivery always finds the sender freed
  p_delivery_frees_tx_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |-> (tx_ready_o && !rx_ready_o));

endmodule

// File: tb/msg_channel_tb.sv
module msg_channel_tb;

  localparam int DW = 8;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          tx_load_i = 1'b0;
  logic [DW-1:0] tx_data_i = '0;
  logic          tx_ready_o;
  logic          rx_read_i = 1'b0;
  logic          rx_ready_o;
  logic          rx_wait_o;
  logic          rx_valid_o;
  logic [DW-1:0] rx_data_o;

  int checks = 0;
  int errors = 0;
  int deliveries = 0;
  bit done = 1'b0;
  logic [DW-1:0] exp_q[$];

  always #2.5 clk_i = ~clk_i;

  msg_channel #(.DATA_W(DW)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .tx_load_i(tx_load_i), .tx_data_i(tx_data_i), .tx_ready_o(tx_ready_o),
    .rx_read_i(rx_read_i), .rx_ready_o(rx_ready_o), .rx_wait_o(rx_wait_o),
    .rx_valid_o(rx_valid_o), .rx_data_o(rx_data_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk_i);
    #1;
  endtask

  // driver: holds load until accepted, records expected word
  task automatic send(input logic [DW-1:0] d);
    bit acc;
    tx_load_i = 1'b1;
    tx_data_i = d;
    do begin
      acc = tx_ready_o;
      if (acc) exp_q.push_back(d);
      cyc();
    end while (!acc);
    tx_load_i = 1'b0;
  endtask

  // monitor: scoreboard compare on each delivery (R9 ordering)
  always @(negedge clk_i) begin
    if (rst_ni && rx_valid_o) begin
      deliveries++;
      if (exp_q.size() == 0) begin
        check(1'b0, "R9 unexpected delivery", rx_data_o, 0);
      end else begin
        logic [DW-1:0] e;
        e = exp_q.pop_front();
        check(rx_data_o == e, "R9 delivery order", rx_data_o, e);
      end
    end
  end

  initial begin
    #(5.0 * 100000);
    check(1'b0, "watchdog", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int base;
    repeat (3) cyc();
    // R1 reset state
    check(tx_ready_o == 1'b1, "R1 tx_ready", tx_ready_o, 1);
    check(rx_ready_o == 1'b0, "R1 rx_ready", rx_ready_o, 0);
    check(rx_wait_o == 1'b0 && rx_valid_o == 1'b0, "R1 wait/valid",
          {rx_wait_o, rx_valid_o}, 0);
    check(rx_data_o == '0, "R1 rx_data", rx_data_o, 0);
    rst_ni = 1'b1;
    cyc();

    // sender-started transaction
    send(8'hA5);
    check(!tx_ready_o && rx_ready_o, "R2 flags after load", {tx_ready_o, rx_ready_o}, 2'b01);
    tx_load_i = 1'b1; tx_data_i = 8'h3C;
    cyc();
    tx_load_i = 1'b0;
    check(!tx_ready_o && rx_ready_o, "R3 flags after ignored load",
          {tx_ready_o, rx_ready_o}, 2'b01);
    rx_read_i = 1'b1;
    cyc();
    rx_read_i = 1'b0;
    check(rx_valid_o && rx_data_o == 8'hA5, "R3 R4 delivered word", rx_data_o, 8'hA5);
    check(tx_ready_o && !rx_ready_o, "R4 flags after read", {tx_ready_o, rx_ready_o}, 2'b10);
    cyc();
    check(!rx_valid_o, "R5 pulse ends", rx_valid_o, 0);
    check(rx_data_o == 8'hA5, "R5 data held", rx_data_o, 8'hA5);

    // receiver-started transaction
    rx_read_i = 1'b1;
    cyc();
    rx_read_i = 1'b0;
    check(rx_wait_o && !rx_ready_o, "R6 blocked", {rx_wait_o, rx_ready_o}, 2'b10);
    repeat (3) cyc();
    check(rx_wait_o && !rx_valid_o, "R6 still blocked", {rx_wait_o, rx_valid_o}, 2'b10);
    rx_read_i = 1'b1;
    cyc();
    rx_read_i = 1'b0;
    check(rx_wait_o && !rx_valid_o, "R9 stray read ignored", {rx_wait_o, rx_valid_o}, 2'b10);
    base = deliveries;
    send(8'h5A);
    check(rx_ready_o && rx_wait_o, "R7 word seen while blocked", {rx_ready_o, rx_wait_o}, 2'b11);
    cyc();
    check(rx_valid_o && rx_data_o == 8'h5A, "R7 completed", rx_data_o, 8'h5A);
    check(!rx_wait_o && !rx_ready_o, "R7 released", {rx_wait_o, rx_ready_o}, 0);
    repeat (4) cyc();
    check(deliveries == base + 1, "R9 single delivery", deliveries - base, 1);

    // read and load in the same cycle
    send(8'h11);
    fork
      send(8'h22);
      begin
        rx_read_i = 1'b1;
        cyc();
        rx_read_i = 1'b0;
        check(rx_valid_o && rx_data_o == 8'h11, "R8 old word first", rx_data_o, 8'h11);
        check(tx_ready_o, "R8 sender freed", tx_ready_o, 1);
      end
    join
    check(rx_ready_o && !tx_ready_o, "R8 new word accepted next", {rx_ready_o, tx_ready_o}, 2'b10);
    check(rx_data_o == 8'h11, "R8 output not yet new", rx_data_o, 8'h11);
    rx_read_i = 1'b1;
    cyc();
    rx_read_i = 1'b0;
    check(rx_valid_o && rx_data_o == 8'h22, "R8 second word", rx_data_o, 8'h22);
    cyc();

    // mixed traffic
    fork
      for (int i = 0; i < 40; i++) begin
        repeat ($urandom % 4) cyc();
        send(DW'((i * 37 + 5) & 8'hFF));
      end
      for (int j = 0; j < 40; j++) begin
        repeat ($urandom % 4) cyc();
        rx_read_i = 1'b1;
        cyc();
        rx_read_i = 1'b0;
        while (!rx_valid_o) cyc();
      end
    join
    repeat (3) cyc();
    check(exp_q.size() == 0, "R9 all words delivered", exp_q.size(), 0);
    check(tx_ready_o && !rx_ready_o && !rx_wait_o, "R2 R6 idle after traffic",
          {tx_ready_o, rx_ready_o, rx_wait_o}, 3'b100);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule